// File: doc/BRIEF.md
# 8-bit Register Load Executor

This block executes a small subset of 8-bit load instructions. Instruction bytes arrive one at a time over a valid/ready interface. The block acts on a file of eight 8-bit registers. One group of opcodes copies one register into another. The other group writes a register from the byte that follows the opcode. A 64-bit counter adds up the cycle cost of every instruction that completes.

Any opcode outside the two groups traps the block. It stops taking bytes and raises an error flag until reset. This includes the forms that name a memory operand through field code 6.

A read port exposes any register combinationally. While the block is idle, a write port lets the surrounding logic preload values.

Top module: `byte_move_exec`

## Requirements
- R1: After reset every register reads 0x00, the cycle counter is 0, `in_ready` is 1, `busy` is 0 and `err` is 0.
- R2: An opcode of the form 01 ddd sss, with neither field equal to 6, copies the register coded by sss into the register coded by ddd. The codes are B=0, C=1, D=2, E=3, H=4, L=5 and A=7. All other registers keep their values, and a copy of a register onto itself leaves it unchanged.
- R3: A copy consumes exactly one byte. `in_ready` is low in the clock after the opcode is taken and high again in the clock after that.
- R4: An opcode of the form 00 ddd 110 with ddd not 6 (0x06 B, 0x0E C, 0x16 D, 0x1E E, 0x26 H, 0x2E L, 0x3E A) takes the next accepted byte as data, whatever its value, and writes it into register ddd.
- R5: Any other opcode sets `err`, including 0x36, 0x76 and every 01 form with a field equal to 6. `err` holds until reset, `in_ready` stays low, and no register or counter value changes.
- R6: The cycle counter grows by 4 for each copy and by 8 for each immediate load, in the clock in which the register is written.
- R7: `rd_data` shows the register picked by `rd_sel` using the R2 codes. Code 6 selects the F register, which no instruction writes.
- R8: `wr_en` writes `wr_data` into the register at `wr_sel` only while `busy` is low. While an immediate load waits for its data, or while trapped, the request is ignored.
- R9: With `in_valid` held high, a stream made of an immediate load, a copy, another immediate load and another copy completes in 10 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte taken when high together with in_valid |
| busy | output | 1 | An instruction is in progress, or the block is trapped |
| err | output | 1 | Unsupported opcode seen; held until reset |
| cyc_count | output | 64 | Accumulated instruction cycle cost |
| rd_sel | input | 3 | Register select for the read port |
| rd_data | output | 8 | Selected register value |
| wr_en | input | 1 | Preload write request |
| wr_sel | input | 3 | Register select for the preload write |
| wr_data | input | 8 | Preload value |

## Verification
The hardest case to reach from the ports is a preload write that arrives while an instruction is only half done. The copy's execute cycle is a single clock, so the bench instead parks the block in the immediate-data fetch. It sends an immediate opcode, withholds the data byte, and raises `wr_en` during that gap. It also raises `wr_en` after a trap. A full sweep of all 256 opcodes runs over distinct preloaded register contents, each opcode after a fresh reset, so every copy pair and every rejected code is covered.

// File: rtl/byte_move_exec.sv
module byte_move_exec #(
  parameter int CW        = 64,
  parameter int MOVE_COST = 4,
  parameter int IMM_COST  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  output logic          in_ready,
  output logic          busy,
  output logic          err,
  output logic [CW-1:0] cyc_count,
  input  logic [2:0]    rd_sel,
  output logic [7:0]    rd_data,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [7:0]    wr_data
);
  localparam logic [CW-1:0] MOVE_INC = CW'(MOVE_COST);
  localparam logic [CW-1:0] IMM_INC  = CW'(IMM_COST);
  localparam logic [2:0]    MEM_CODE = 3'd6;

  typedef enum logic [1:0] {FETCH_OP, FETCH_IMM, EXEC, TRAPPED} st_t;
  st_t st;

  logic [7:0] rf [8];
  logic [2:0] dst_q, src_q;
  logic       move_q;
  logic [7:0] imm_q;

  wire take     = in_valid && in_ready;
  wire dec_move = in_byte[7:6] == 2'b01 && in_byte[5:3] != MEM_CODE && in_byte[2:0] != MEM_CODE;
  wire dec_imm  = in_byte[7:6] == 2'b00 && in_byte[2:0] == MEM_CODE && in_byte[5:3] != MEM_CODE;
  wire [7:0] wb_val = move_q ? rf[src_q] : imm_q;

  assign in_ready = st == FETCH_OP || st == FETCH_IMM;
  assign busy     = st != FETCH_OP;
  assign err      = st == TRAPPED;
  assign rd_data  = rf[rd_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= FETCH_OP;
      dst_q  <= '0;
      src_q  <= '0;
      move_q <= 1'b0;
      imm_q  <= '0;
    end else begin
      case (st)
        FETCH_OP: if (take) begin
          dst_q  <= in_byte[5:3];
          src_q  <= in_byte[2:0];
          move_q <= dec_move;
          if (dec_move)     st <= EXEC;
          else if (dec_imm) st <= FETCH_IMM;
          else              st <= TRAPPED;
        end
        FETCH_IMM: if (take) begin
          imm_q <= in_byte;
          st    <= EXEC;
        end
        EXEC:    st <= FETCH_OP;
        default: st <= TRAPPED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= '0;
      cyc_count <= '0;
    end else if (st == EXEC) begin
      rf[dst_q] <= wb_val;
      cyc_count <= cyc_count + (move_q ? MOVE_INC : IMM_INC);
    end else if (st == FETCH_OP && wr_en) begin
      rf[wr_sel] <= wr_data;
    end
  end
endmodule

// File: rtl/byte_move_exec_chk.sv
module byte_move_exec_chk #(
  parameter int CW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [7:0]    in_byte,
  input logic          in_ready,
  input logic          busy,
  input logic          err,
  input logic [CW-1:0] cyc_count
);
  wire op_take  = in_valid && in_ready && !busy;
  wire bad_move = in_byte[7:6] == 2'b01 && (in_byte[5:3] == 3'd6 || in_byte[2:0] == 3'd6);
  wire ok_move  = in_byte[7:6] == 2'b01 && !bad_move;

  a_r5_trap_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !in_ready);
  a_r5_trap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r5_trap_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> $stable(cyc_count));
  a_r5_mem_form_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (op_take && bad_move) |=> err);
  a_r3_move_stalls_once: assert property (@(posedge clk) disable iff (!rst_n)
    (op_take && ok_move) |=> (busy && !in_ready && !err));
  a_r6_cost_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cyc_count == $past(cyc_count) || cyc_count == $past(cyc_count) + CW'(4)
              || cyc_count == $past(cyc_count) + CW'(8)));
  a_r9_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> in_ready);
endmodule

bind byte_move_exec byte_move_exec_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
  .in_ready(in_ready), .busy(busy), .err(err), .cyc_count(cyc_count)
);

// File: tb/byte_move_exec_bench.sv
`timescale 1ns/1ps
module byte_move_exec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_ready, busy, err;
  logic [63:0] cyc_count;
  logic [2:0]  rd_sel = '0;
  logic [7:0]  rd_data;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;

  int nvec = 0, nbad = 0, edges = 0;
  logic [7:0] exp_rf [8];

  always #4 clk = ~clk;
  always @(posedge clk) edges++;

  byte_move_exec u_byte_move_exec (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit drop);
    bit rdy;
    in_valid = 1'b1; in_byte = b;
    forever begin
      rdy = in_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    if (drop) in_valid = 1'b0;
  endtask

  task automatic check_rf(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_sel = 3'(i);
      #0.4;
      chk(rd_data == exp_rf[i], req, $sformatf("reg code %0d", i), rd_data, exp_rf[i]);
    end
  endtask

  task automatic preload(input int seed);
    for (int i = 0; i < 8; i++) begin
      exp_rf[i] = 8'((seed * 7 + i * 37 + 1) & 255);
      wr(3'(i), exp_rf[i]);
    end
  endtask

  initial begin
    logic [63:0] exp_cyc;
    int t0;
    do_reset();
    // R1 reset state
    for (int i = 0; i < 8; i++) exp_rf[i] = 8'h00;
    check_rf("R1");
    chk(cyc_count == 0, "R1", "cyc_count", cyc_count, 0);
    chk(in_ready && !busy && !err, "R1", "ready/busy/err", {in_ready, busy, err}, 3'b100);

    // R2 R3 R4 R5 R6 R7: full opcode sweep
    for (int op = 0; op < 256; op++) begin
      logic [1:0] g;
      logic [2:0] d, s;
      logic [7:0] imm;
      bit is_mv, is_im;
      do_reset();
      preload(op);
      check_rf("R7");
      g = 2'(op >> 6); d = 3'((op >> 3) & 7); s = 3'(op & 7);
      imm = 8'(op ^ 8'h40);
      is_mv = (g == 2'b01) && d != 3'd6 && s != 3'd6;
      is_im = (g == 2'b00) && s == 3'd6 && d != 3'd6;
      send(8'(op), 1'b1);
      if (is_mv) begin
        chk(!in_ready && busy, "R3", $sformatf("stall after copy %0h", op), in_ready, 0);
        @(negedge clk);
        chk(in_ready && !busy, "R3", $sformatf("ready again after %0h", op), in_ready, 1);
        exp_rf[d] = exp_rf[s];
        exp_cyc = 64'd4;
        check_rf("R2");
      end else if (is_im) begin
        send(imm, 1'b1);
        @(negedge clk);
        exp_rf[d] = imm;
        exp_cyc = 64'd8;
        check_rf("R4");
      end else begin
        @(negedge clk);
        chk(err && !in_ready, "R5", $sformatf("trap on %0h", op), {err, in_ready}, 2'b10);
        exp_cyc = 64'd0;
        check_rf("R5");
      end
      chk(cyc_count == exp_cyc, "R6", $sformatf("count after %0h", op), cyc_count, exp_cyc);
    end

    // R8: write during imm wait and during trap is ignored; idle write lands
    do_reset();
    preload(3);
    send(8'h06, 1'b1);
    wr(3'd3, 8'hEE);
    send(8'h12, 1'b1);
    @(negedge clk);
    exp_rf[0] = 8'h12;
    check_rf("R8");
    wr(3'd6, 8'h9C);
    exp_rf[6] = 8'h9C;
    check_rf("R8");
    send(8'h76, 1'b1);
    wr(3'd7, 8'h55);
    @(negedge clk);
    chk(err, "R8", "trapped", err, 1);
    check_rf("R8");

    // R9: back-to-back stream with valid held high
    do_reset();
    preload(11);
    t0 = edges;
    send(8'h3E, 1'b0); send(8'h5A, 1'b0);
    send(8'h47, 1'b0);
    send(8'h0E, 1'b0); send(8'h33, 1'b0);
    send(8'h79, 1'b1);
    @(negedge clk);
    chk(edges - t0 == 10, "R9", "stream clocks", 64'(edges - t0), 10);
    exp_rf[7] = 8'h33; exp_rf[0] = 8'h5A; exp_rf[1] = 8'h33;
    check_rf("R9");
    chk(cyc_count == 64'd24, "R6", "stream count", cyc_count, 24);
    summary();
  end
endmodule